// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 32 level-high interrupt sources and presents them to a processor on two separate lines. One line is for normal interrupts and one is for fast interrupts. Each of the two banks keeps its own enable mask and its own software-interrupt bit, and it shows the processor two views of the sources: the raw lines and the lines after masking. Each peripheral clears its own request line, so the controller holds no per-source latch. Source numbering follows the platform convention. Bit 1 is the software interrupt, bits 4 to 7 are the four timers, and bits 28 to 31 are the PCI data-parity, master-abort, target-abort and general-parity error sources.

The processor reaches both banks over a plain word-wide register bus. Reads are combinational from the address. A write takes effect on the clock edge where `bus_wr` is high. The bus has no flow control: a write always completes in one cycle, and read data is valid in the same cycle as its address. The normal bank sits at byte offsets 0x00 to 0x10. The fast bank repeats that layout 0x100 higher. Within a bank, the enable mask has no direct write port. Software changes it only through a write-1-to-set register and a write-1-to-clear register, and the mask is read back at the address of the set register.

Top module: `irq_ctl_dual`

## Requirements
- R1: Offset 0x04 of a bank reads the raw sources, whether or not they are enabled. In that view bit 1 is the OR of `src_i[1]` and that bank's software bit.
- R2: Offset 0x00 of a bank reads the bitwise AND of that bank's raw view (R1) and its enable mask.
- R3: A write to offset 0x08 sets every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged. A read of 0x08 returns the enable mask.
- R4: A write to offset 0x0C clears every enable bit whose write-data bit is 1. Bits written as 0 have no effect.
- R5: A write to offset 0x10 loads write-data bit 1 into the bank's software bit. All other data bits have no effect.
- R6: The fast bank uses the same offsets plus 0x100 (address bit 8 = 1). Its enable mask and software bit are separate from the normal bank's and do not change when the normal bank is written.
- R7: `irq_o` and `fiq_o` are registered. Each equals the OR of its bank's masked view as it stood one clock earlier.
- R8: Reset (`rst_n` low) clears both enable masks, both software bits and both output lines.
- R9: Writes to offsets 0x00 and 0x04 change nothing. Reads of 0x0C, 0x10 and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-high interrupt sources |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 9 | Byte address; bit 8 selects the fast bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Two things can happen in the same cycle: software changes the enable mask, and a peripheral drops or raises its source line. The bench provokes this by writing a set mask to a bank in the very cycle that the matching source falls. It then checks that the output line stays low and that the mask still reads back with the new bit. It also writes 0 to the software bit while `src_i[1]` is held high, and checks that raw bit 1 stays set because the hardware source remains active.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC       = 32;
  localparam int ADDR_W     = 9;
  localparam int NBANK      = 2;
  localparam int SOFT_BIT   = 1;
  // register offsets within a bank
  localparam logic [7:0] OFF_MASKED = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_ENSET  = 8'h08;
  localparam logic [7:0] OFF_ENCLR  = 8'h0C;
  localparam logic [7:0] OFF_SOFT   = 8'h10;
  // source numbering
  localparam int SRC_TMR_LO = 4;
  localparam int SRC_TMR_HI = 7;
  localparam int SRC_PCI_DPAR = 28;
  localparam int SRC_PCI_MABT = 29;
  localparam int SRC_PCI_TABT = 30;
  localparam int SRC_PCI_GPAR = 31;
  typedef logic [NSRC-1:0] word_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t src,
  input  logic  wr_set,
  input  logic  wr_clr,
  input  logic  wr_soft,
  input  word_t wdata,
  output word_t en_mask,
  output word_t raw,
  output word_t masked,
  output logic  line_q
);
  word_t en_q;
  logic  soft_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      soft_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      en_q <= (en_q | (wr_set ? wdata : '0)) & ~(wr_clr ? wdata : '0);
      if (wr_soft) soft_q <= wdata[SOFT_BIT];
      line_q <= |masked;
    end
  end

  always_comb begin
    raw = src;
    raw[SOFT_BIT] = src[SOFT_BIT] | soft_q;
  end

  assign masked  = raw & en_q;
  assign en_mask = en_q;

  // R3: bits written to the set register are enabled afterwards
  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && !wr_clr |=> ((en_q & $past(wdata)) == $past(wdata)));
  // R4: bits written to the clear register are disabled afterwards
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(wdata)) == '0));
  // R3: no mask write, mask holds
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set && !wr_clr |=> $stable(en_q));
  // R5: software bit follows data bit 1
  a_r5_soft_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_soft |=> (soft_q == $past(wdata[SOFT_BIT])));
  // R7: line is the registered OR of the masked view
  a_r7_line_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (line_q == $past(|masked)));
endmodule

// File: rtl/irq_ctl_dual.sv
module irq_ctl_dual
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] off;
  logic             bank_sel;
  word_t            en_v   [NBANK];
  word_t            raw_v  [NBANK];
  word_t            msk_v  [NBANK];
  logic  [NBANK-1:0] line_v;
  logic  [NBANK-1:0] set_v, clr_v, soft_v;

  assign off      = bus_addr[OFF_W-1:0];
  assign bank_sel = bus_addr[ADDR_W-1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit      = bus_wr && (bank_sel == b[0]);
    assign set_v[b]  = hit && (off == OFF_ENSET);
    assign clr_v[b]  = hit && (off == OFF_ENCLR);
    assign soft_v[b] = hit && (off == OFF_SOFT);

    irq_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_i),
      .wr_set  (set_v[b]),
      .wr_clr  (clr_v[b]),
      .wr_soft (soft_v[b]),
      .wdata   (bus_wdata),
      .en_mask (en_v[b]),
      .raw     (raw_v[b]),
      .masked  (msk_v[b]),
      .line_q  (line_v[b])
    );
  end

  always_comb begin
    case (off)
      OFF_MASKED: bus_rdata = msk_v[bank_sel];
      OFF_RAW:    bus_rdata = raw_v[bank_sel];
      OFF_ENSET:  bus_rdata = en_v[bank_sel];
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = line_v[0];
  assign fiq_o = line_v[1];

  // R6: at most one bank register is written in any cycle
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_v, clr_v, soft_v}));
  // R8: lines low in the cycle after reset
  a_r8_lines_reset: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && !fiq_o));
  // R9: read-only offsets are never decoded as writes
  a_r9_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (off == OFF_MASKED || off == OFF_RAW) |-> (set_v == '0 && clr_v == '0 && soft_v == '0));
endmodule

// File: tb/irq_ctl_dual_bench.sv
module irq_ctl_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_ctl_dual u_irq_ctl_dual (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 9'h008, 32'h0, 32'h0,         32'h0,         4'd8}, // R8 mask clear
    '{1'b0, 9'h004, 32'h0, 32'h8000_0010, 32'h8000_0010, 4'd1}, // R1 raw
    '{1'b0, 9'h000, 32'h0, 32'h8000_0010, 32'h0,         4'd2}, // R2 masked
    '{1'b1, 9'h008, 32'h0000_00F0, 32'h8000_0010, 32'h0, 4'd3},
    '{1'b0, 9'h008, 32'h0, 32'h8000_0010, 32'h0000_00F0, 4'd3}, // R3
    '{1'b0, 9'h000, 32'h0, 32'h8000_0010, 32'h0000_0010, 4'd2}, // R2
    '{1'b1, 9'h008, 32'h8000_0000, 32'h0, 32'h0,         4'd3},
    '{1'b0, 9'h008, 32'h0, 32'h0,         32'h8000_00F0, 4'd3}, // R3 others kept
    '{1'b1, 9'h00C, 32'h0000_0030, 32'h0, 32'h0,         4'd4},
    '{1'b0, 9'h008, 32'h0, 32'h0,         32'h8000_00C0, 4'd4}, // R4
    '{1'b0, 9'h000, 32'h0, 32'h8000_00FF, 32'h8000_00C0, 4'd2}, // R2
    '{1'b1, 9'h010, 32'hFFFF_FFFD, 32'h0, 32'h0,         4'd5},
    '{1'b0, 9'h004, 32'h0, 32'h0,         32'h0,         4'd5}, // R5 other bits ignored
    '{1'b1, 9'h010, 32'h0000_0002, 32'h0, 32'h0,         4'd5},
    '{1'b0, 9'h004, 32'h0, 32'h0,         32'h0000_0002, 4'd5}, // R5 soft raises bit 1
    '{1'b0, 9'h104, 32'h0, 32'h0,         32'h0,         4'd6}, // R6 fast soft separate
    '{1'b0, 9'h108, 32'h0, 32'h0,         32'h0,         4'd6}, // R6
    '{1'b1, 9'h108, 32'h0000_0002, 32'h0, 32'h0,         4'd6},
    '{1'b0, 9'h108, 32'h0, 32'h0,         32'h0000_0002, 4'd6}, // R6
    '{1'b0, 9'h008, 32'h0, 32'h0,         32'h8000_00C0, 4'd6}, // R6 normal unchanged
    '{1'b1, 9'h000, 32'hFFFF_FFFF, 32'h0, 32'h0,         4'd9},
    '{1'b0, 9'h008, 32'h0, 32'h0,         32'h8000_00C0, 4'd9}, // R9
    '{1'b1, 9'h004, 32'hFFFF_FFFF, 32'h0, 32'h0,         4'd9},
    '{1'b0, 9'h004, 32'h0, 32'h0,         32'h0000_0002, 4'd9}, // R9
    '{1'b0, 9'h00C, 32'h0, 32'h0,         32'h0,         4'd9}, // R9
    '{1'b0, 9'h010, 32'h0, 32'h0,         32'h0,         4'd9}, // R9
    '{1'b0, 9'h01C, 32'h0, 32'h0,         32'h0,         4'd9}, // R9 unmapped
    '{1'b1, 9'h110, 32'h0000_0002, 32'h0, 32'h0,         4'd6},
    '{1'b0, 9'h104, 32'h0, 32'h0,         32'h0000_0002, 4'd1}, // R1 fast raw
    '{1'b0, 9'h100, 32'h0, 32'h0,         32'h0000_0002, 4'd2}, // R2 fast masked
    '{1'b0, 9'h110, 32'h0, 32'h0,         32'h0,         4'd9}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input string req, input logic [31:0] exp);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 lines after reset", {30'd0, irq_o, fiq_o}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_i = TBL[i].src;
      bus_addr = TBL[i].addr;
      if (TBL[i].wr) begin
        bus_wdata = TBL[i].data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
      end else begin
        #1 check($sformatf("R%0d vector %0d", TBL[i].req, i), bus_rdata, TBL[i].exp);
      end
    end
    // R7: fast bank has bit 1 enabled and soft set -> fiq_o high; normal bit 1 not enabled
    @(negedge clk);
    check("R7 fiq line", {31'd0, fiq_o}, 32'h1);
    check("R7 irq line idle", {31'd0, irq_o}, 32'h0);
    // R7: source 7 enabled in normal bank; line follows one edge later
    src_i = 32'h0000_0080;
    #1 check("R7 irq before edge", {31'd0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 irq after edge", {31'd0, irq_o}, 32'h1);
    src_i = 32'h0;
    @(negedge clk);
    check("R7 irq drops", {31'd0, irq_o}, 32'h0);
    // same cycle: enable bit 5 set while source 5 falls
    src_i = 32'h0000_0020;
    @(negedge clk);
    bus_addr = 9'h008; bus_wdata = 32'h0000_0020; bus_wr = 1'b1; src_i = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    check("R7 no line after source fell", {31'd0, irq_o}, 32'h0);
    rd(9'h008, "R3 mask after concurrent set", 32'h8000_00E0);
    // soft cleared while hardware source 1 is high: raw bit 1 stays
    src_i = 32'h0000_0002;
    wr(9'h010, 32'h0);
    rd(9'h004, "R1 hw source 1 with soft clear", 32'h0000_0002);
    src_i = 32'h0;
    rd(9'h004, "R5 soft cleared", 32'h0);
    // R8: reset mid-run
    wr(9'h010, 32'h2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(9'h008, "R8 normal mask", 32'h0);
    rd(9'h108, "R8 fast mask", 32'h0);
    rd(9'h104, "R8 fast soft", 32'h0);
    rd(9'h004, "R8 normal soft", 32'h0);
    check("R8 lines", {30'd0, irq_o, fiq_o}, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule